// File: doc/BRIEF.md
# Colour-Key Overlay Selector

This block sits at the end of a display pipeline and makes a per-pixel choice between a graphics pixel and an overlay pixel. Each pixel comes with an overlay index and red, green and blue components. Each of these four channels is tested against a programmable inclusive window. The window is a pair of low and high bounds. The channel results are combined into one key: every enabled channel must fall inside its window, and a negate bit can invert the outcome. When the key is true, the overlay pixel is shown.

A zoom setting lets the same key decision cover a run of 1, 2, 4, 8, 16 or 32 valid pixels. This suits an overlay that is drawn at a lower horizontal resolution than the graphics plane. Software sets up the block through a simple write port. The block registers its select output, and delays the chosen pixel by the same one cycle.

Top module: `ckey_overlay_sel`

## Requirements
- R1: After reset, every window bound reads as all-ones, all four channels are disabled, negate is off and the zoom factor is 1. The first pixels after reset therefore show the graphics pixel. With only the overlay channel enabled and no bounds written, an index of 0xFF is keyed and 0xFE is not.
- R2: Writes land as follows. Addresses 0 to 7 hold the window bounds, low then high, for overlay index (0,1), red (2,3), green (4,5) and blue (6,7). Address 8 is the control byte. Writes to addresses 9 to 15 change nothing.
- R3: A channel is inside its window when low <= value <= high. Both bounds are inclusive.
- R4: Control bits 0, 1, 2 and 3 enable the overlay, red, green and blue channels. A disabled channel does not veto the key. The key before negation is the AND of the enabled channels' window results.
- R5: When no channel is enabled, the key before negation is false.
- R6: Control bit 4 inverts the final key. This also applies when no channel is enabled.
- R7: Control bits 7:5 set the zoom. Codes 0 to 5 give N = 1, 2, 4, 8, 16, 32, and codes 6 and 7 also give 32. The key is evaluated on the first of every N valid pixels and reused for the next N-1 valid pixels. A control write restarts the count, so the next valid pixel is evaluated afresh.
- R8: Select, output pixel and output-valid are registered and appear one clock after a valid input pixel. The output pixel is the overlay pixel when select is 1 and the graphics pixel otherwise.
- R9: In a cycle without a valid input pixel, output-valid is 0 on the next clock and select and output pixel keep their values.
- R10: A window whose low bound exceeds its high bound never matches, so an enabled channel with such a window keeps the key false before negation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register write address |
| regWrData | input | COMP_W | Register write data |
| pixValid | input | 1 | Input pixel valid |
| ovlIdx | input | COMP_W | Overlay index of the current pixel |
| red | input | COMP_W | Red component |
| green | input | COMP_W | Green component |
| blue | input | COMP_W | Blue component |
| gfxPixel | input | PIX_W | Graphics pixel |
| ovlPixel | input | PIX_W | Overlay pixel |
| selOverlay | output | 1 | 1 when the overlay pixel is shown |
| pixOut | output | PIX_W | Chosen pixel |
| pixOutValid | output | 1 | Output pixel valid |

## Verification
A corrupted window bound or enable bit shows up as a wrong select on the very next pixel whose value sits on that bound. The bench therefore drives values exactly at, just inside and just outside each bound. A zoom phase counter that drifts or fails to restart after a control write shows up within one zoom group. It appears as a select that changes mid-group or stays stuck one pixel too long, so groups of 4 and 32 are walked pixel by pixel. A stale held key shows up on the second pixel of a group, one clock after that pixel is accepted.

// File: rtl/ckey_pkg.sv
package ckey_pkg;
  localparam int NUM_CH       = 4;   // overlay index, red, green, blue
  localparam int CH_OVL       = 0;
  localparam int CH_RED       = 1;
  localparam int CH_GRN       = 2;
  localparam int CH_BLU       = 3;
  localparam int CTRL_ADDR    = 2 * NUM_CH;
  localparam int NEG_BIT      = 4;
  localparam int ZOOM_LSB     = 5;
  localparam int ZOOM_W       = 3;
  localparam int ZOOM_MAX_LOG = 5;   // largest group is 2**5 pixels
  localparam int CTRL_W       = ZOOM_LSB + ZOOM_W;

  // strobes handed from the control side to the datapath
  typedef struct packed {
    logic              sampleNow;
    logic [NUM_CH-1:0] chanEn;
    logic              negate;
  } ckey_strobe_t;
endpackage

// File: rtl/ckey_ctrl.sv
module ckey_ctrl
  import ckey_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [COMP_W-1:0]              regWrData,
  input  logic                           pixValid,
  output ckey_strobe_t                   strobe,
  output logic [NUM_CH-1:0][COMP_W-1:0]  rangeLo,
  output logic [NUM_CH-1:0][COMP_W-1:0]  rangeHi
);
  localparam int PH_W = ZOOM_MAX_LOG;

  logic [CTRL_W-1:0] ctrlReg;
  logic              ctrlWr;
  logic [ZOOM_W-1:0] zoomCode;
  logic [ZOOM_W-1:0] zoomLog;
  logic [PH_W:0]     groupLen;
  logic [PH_W-1:0]   lastPhase;
  logic [PH_W-1:0]   phase;

  // window bound registers, one low/high pair per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_range
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rangeLo[ch] <= '1;
        rangeHi[ch] <= '1;
      end else if (regWrEn) begin
        if (regAddr == ADDR_W'(2 * ch))     rangeLo[ch] <= regWrData;
        if (regAddr == ADDR_W'(2 * ch + 1)) rangeHi[ch] <= regWrData;
      end
    end
  end

  assign ctrlWr = regWrEn && (regAddr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN)       ctrlReg <= '0;
    else if (ctrlWr) ctrlReg <= regWrData[CTRL_W-1:0];
  end

  assign zoomCode  = ctrlReg[ZOOM_LSB +: ZOOM_W];
  assign zoomLog   = (zoomCode > ZOOM_W'(ZOOM_MAX_LOG)) ? ZOOM_W'(ZOOM_MAX_LOG) : zoomCode;
  assign groupLen  = {{PH_W{1'b0}}, 1'b1} << zoomLog;
  assign lastPhase = PH_W'(groupLen - 1'b1);

  // position of the current valid pixel inside its zoom group
  always_ff @(posedge clk) begin
    if (!rstN)         phase <= '0;
    else if (ctrlWr)   phase <= '0;
    else if (pixValid) phase <= (phase == lastPhase) ? '0 : phase + 1'b1;
  end

  assign strobe.sampleNow = pixValid && (phase == '0);
  assign strobe.chanEn    = ctrlReg[NUM_CH-1:0];
  assign strobe.negate    = ctrlReg[NEG_BIT];

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    phase <= lastPhase); // R7
  AST_CTRL_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (phase == '0)); // R7
  AST_OVL_LO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == '0) |=> (rangeLo[CH_OVL] == $past(regWrData))); // R2
  AST_BLU_HI_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(2 * CH_BLU + 1)) |=> (rangeHi[CH_BLU] == $past(regWrData))); // R2
endmodule

// File: rtl/ckey_datapath.sv
module ckey_datapath
  import ckey_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int PIX_W  = 24
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ckey_strobe_t                   strobe,
  input  logic                           pixValid,
  input  logic [NUM_CH-1:0][COMP_W-1:0]  chanVal,
  input  logic [NUM_CH-1:0][COMP_W-1:0]  rangeLo,
  input  logic [NUM_CH-1:0][COMP_W-1:0]  rangeHi,
  input  logic [PIX_W-1:0]               gfxPixel,
  input  logic [PIX_W-1:0]               ovlPixel,
  output logic                           selOverlay,
  output logic [PIX_W-1:0]               pixOut,
  output logic                           pixOutValid
);
  logic [NUM_CH-1:0] inWin;
  logic [NUM_CH-1:0] chanOk;
  logic              rawKey;
  logic              freshKey;
  logic              heldKey;
  logic              effKey;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    assign inWin[ch]  = (chanVal[ch] >= rangeLo[ch]) && (chanVal[ch] <= rangeHi[ch]);
    assign chanOk[ch] = !strobe.chanEn[ch] || inWin[ch];
  end

  assign rawKey   = (|strobe.chanEn) && (&chanOk);
  assign freshKey = rawKey ^ strobe.negate;
  assign effKey   = strobe.sampleNow ? freshKey : heldKey;

  // decision kept for the rest of the zoom group
  always_ff @(posedge clk) begin
    if (!rstN)                 heldKey <= 1'b0;
    else if (strobe.sampleNow) heldKey <= freshKey;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selOverlay  <= 1'b0;
      pixOut      <= '0;
      pixOutValid <= 1'b0;
    end else begin
      pixOutValid <= pixValid;
      if (pixValid) begin
        selOverlay <= effKey;
        pixOut     <= effKey ? ovlPixel : gfxPixel;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> pixOutValid); // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !pixOutValid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> ($stable(selOverlay) && $stable(pixOut))); // R9
  AST_PIX_MUX: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> (pixOut == (selOverlay ? $past(ovlPixel) : $past(gfxPixel)))); // R8
  AST_GROUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !strobe.sampleNow) |=> $stable(selOverlay)); // R7
  AST_NO_CHAN_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sampleNow && strobe.chanEn == '0) |=> (selOverlay == $past(strobe.negate))); // R5
endmodule

// File: rtl/ckey_overlay_sel.sv
module ckey_overlay_sel
  import ckey_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int PIX_W  = 24,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [COMP_W-1:0] regWrData,
  input  logic              pixValid,
  input  logic [COMP_W-1:0] ovlIdx,
  input  logic [COMP_W-1:0] red,
  input  logic [COMP_W-1:0] green,
  input  logic [COMP_W-1:0] blue,
  input  logic [PIX_W-1:0]  gfxPixel,
  input  logic [PIX_W-1:0]  ovlPixel,
  output logic              selOverlay,
  output logic [PIX_W-1:0]  pixOut,
  output logic              pixOutValid
);
  ckey_strobe_t                  strobe;
  logic [NUM_CH-1:0][COMP_W-1:0] rangeLo;
  logic [NUM_CH-1:0][COMP_W-1:0] rangeHi;
  logic [NUM_CH-1:0][COMP_W-1:0] chanVal;

  assign chanVal[CH_OVL] = ovlIdx;
  assign chanVal[CH_RED] = red;
  assign chanVal[CH_GRN] = green;
  assign chanVal[CH_BLU] = blue;

  ckey_ctrl #(.COMP_W(COMP_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .pixValid  (pixValid),
    .strobe    (strobe),
    .rangeLo   (rangeLo),
    .rangeHi   (rangeHi)
  );

  ckey_datapath #(.COMP_W(COMP_W), .PIX_W(PIX_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pixValid    (pixValid),
    .chanVal     (chanVal),
    .rangeLo     (rangeLo),
    .rangeHi     (rangeHi),
    .gfxPixel    (gfxPixel),
    .ovlPixel    (ovlPixel),
    .selOverlay  (selOverlay),
    .pixOut      (pixOut),
    .pixOutValid (pixOutValid)
  );
endmodule

// File: tb/ckey_overlay_sel_tb.sv
module ckey_overlay_sel_tb;
  localparam int COMP_W = 8;
  localparam int PIX_W  = 24;
  localparam int ADDR_W = 4;
  localparam int NVEC   = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [COMP_W-1:0] regWrData = '0;
  logic              pixValid = 1'b0;
  logic [COMP_W-1:0] ovlIdx = '0, red = '0, green = '0, blue = '0;
  logic [PIX_W-1:0]  gfxPixel = '0, ovlPixel = '0;
  logic              selOverlay;
  logic [PIX_W-1:0]  pixOut;
  logic              pixOutValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ckey_overlay_sel #(.COMP_W(COMP_W), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .pixValid(pixValid), .ovlIdx(ovlIdx), .red(red), .green(green), .blue(blue),
    .gfxPixel(gfxPixel), .ovlPixel(ovlPixel),
    .selOverlay(selOverlay), .pixOut(pixOut), .pixOutValid(pixOutValid)
  );

  // {control, overlay idx, red, green, blue, expected select}
  // windows: idx 10..20, red 64..128, green 200..200, blue 0xFF..0x00
  localparam logic [47:0] VEC [NVEC] = '{
    {8'h01, 8'd10,  8'd0,   8'd0,   8'd0, 8'd1},  // R3 low bound
    {8'h01, 8'd20,  8'd0,   8'd0,   8'd0, 8'd1},  // R3 high bound
    {8'h01, 8'd21,  8'd0,   8'd0,   8'd0, 8'd0},  // R3 above
    {8'h01, 8'd9,   8'd0,   8'd0,   8'd0, 8'd0},  // R3 below
    {8'h03, 8'd15,  8'd128, 8'd0,   8'd0, 8'd1},  // R4 both in
    {8'h03, 8'd15,  8'd129, 8'd0,   8'd0, 8'd0},  // R4 red out
    {8'h02, 8'd0,   8'd64,  8'd0,   8'd0, 8'd1},  // R4 idx disabled
    {8'h04, 8'd0,   8'd0,   8'd200, 8'd0, 8'd1},  // R3 single-value window
    {8'h04, 8'd0,   8'd0,   8'd201, 8'd0, 8'd0},  // R3
    {8'h08, 8'd0,   8'd0,   8'd0, 8'hFF, 8'd0},   // R10 inverted window
    {8'h00, 8'd15,  8'd100, 8'd200, 8'd0, 8'd0},  // R5
    {8'h10, 8'd15,  8'd100, 8'd200, 8'd0, 8'd1},  // R6 negate, none enabled
    {8'h11, 8'd15,  8'd0,   8'd0,   8'd0, 8'd0},  // R6
    {8'h11, 8'd30,  8'd0,   8'd0,   8'd0, 8'd1},  // R6
    {8'h07, 8'd12,  8'd100, 8'd200, 8'd0, 8'd1},  // R4 three channels
    {8'h07, 8'd12,  8'd100, 8'd199, 8'd0, 8'd0}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [COMP_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // one valid pixel; returns after the output register has taken it
  task automatic pix(input logic [7:0] i, input logic [7:0] r, input logic [7:0] g,
                     input logic [7:0] b, input logic [7:0] tag);
    @(negedge clk);
    pixValid = 1'b1; ovlIdx = i; red = r; green = g; blue = b;
    gfxPixel = {8'hA0, tag, 8'h11};
    ovlPixel = {8'h5B, tag, 8'h22};
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  task automatic chkPix(input string req, input logic expSel, input logic [7:0] tag);
    logic [PIX_W-1:0] expPix;
    expPix = expSel ? {8'h5B, tag, 8'h22} : {8'hA0, tag, 8'h11};
    chk(req, {31'd0, selOverlay}, {31'd0, expSel});
    chk(req, {8'd0, pixOut}, {8'd0, expPix});
    chk(req, {31'd0, pixOutValid}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset select", {31'd0, selOverlay}, 32'd0);
    chk("R1 reset valid", {31'd0, pixOutValid}, 32'd0);
    chk("R1 reset pixel", {8'd0, pixOut}, 32'd0);

    pix(8'd15, 8'd1, 8'd2, 8'd3, 8'h01);
    chkPix("R1 defaults show graphics", 1'b0, 8'h01);

    // default bounds all-ones
    wrReg(4'd8, 8'h01);
    pix(8'hFF, 8'd0, 8'd0, 8'd0, 8'h02);
    chkPix("R1 default bound 0xFF", 1'b1, 8'h02);
    pix(8'hFE, 8'd0, 8'd0, 8'd0, 8'h03);
    chkPix("R1 default bound 0xFE", 1'b0, 8'h03);

    // R2 window map
    wrReg(4'd0, 8'd10);  wrReg(4'd1, 8'd20);
    wrReg(4'd2, 8'd64);  wrReg(4'd3, 8'd128);
    wrReg(4'd4, 8'd200); wrReg(4'd5, 8'd200);
    wrReg(4'd6, 8'hFF);  wrReg(4'd7, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      wrReg(4'd8, VEC[v][47:40]);
      pix(VEC[v][39:32], VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], 8'(8'h10 + v));
      chkPix($sformatf("R2/R3/R4 vector %0d", v), VEC[v][0], 8'(8'h10 + v));
    end

    // R2 unused addresses ignored: control stays idx-enabled, no negate
    wrReg(4'd8, 8'h01);
    for (int a = 9; a < 16; a++) wrReg(4'(a), 8'h10);
    pix(8'd15, 8'd0, 8'd0, 8'd0, 8'h30);
    chkPix("R2 addr 9-15 ignored (in window)", 1'b1, 8'h30);
    pix(8'd30, 8'd0, 8'd0, 8'd0, 8'h31);
    chkPix("R2 addr 9-15 ignored (out of window)", 1'b0, 8'h31);

    // R9 idle hold
    @(negedge clk);
    ovlIdx = 8'd15; gfxPixel = 24'h123456; ovlPixel = 24'h654321;
    @(negedge clk);
    chk("R9 idle valid low", {31'd0, pixOutValid}, 32'd0);
    chk("R9 idle select held", {31'd0, selOverlay}, 32'd0);
    chk("R9 idle pixel held", {8'd0, pixOut}, {8'd0, 24'hA03111});

    // R7 zoom 4 (code 2)
    wrReg(4'd8, 8'h41);
    for (int k = 0; k < 8; k++) begin
      pix((k == 0 || k >= 5) ? 8'd15 : 8'd30, 8'd0, 8'd0, 8'd0, 8'(8'h40 + k));
      chkPix($sformatf("R7 zoom4 pixel %0d", k), k < 4, 8'(8'h40 + k));
    end

    // R7 restart after control write
    pix(8'd15, 8'd0, 8'd0, 8'd0, 8'h50);
    chkPix("R7 restart first", 1'b1, 8'h50);
    pix(8'd30, 8'd0, 8'd0, 8'd0, 8'h51);
    chkPix("R7 restart held", 1'b1, 8'h51);
    wrReg(4'd8, 8'h41);
    pix(8'd30, 8'd0, 8'd0, 8'd0, 8'h52);
    chkPix("R7 restart resampled", 1'b0, 8'h52);

    // R7 code 7 acts as 32
    wrReg(4'd8, 8'hE1);
    for (int k = 0; k < 33; k++) begin
      pix((k == 0) ? 8'd15 : 8'd30, 8'd0, 8'd0, 8'd0, 8'(8'h60 + k));
      chkPix($sformatf("R7 zoom32 pixel %0d", k), k < 32, 8'(8'h60 + k));
    end

    // R8 back-to-back pixels, one-cycle latency
    wrReg(4'd8, 8'h01);
    @(negedge clk);
    pixValid = 1'b1; ovlIdx = 8'd15; gfxPixel = 24'hA0AA11; ovlPixel = 24'h5BAA22;
    chk("R8 not yet valid", {31'd0, pixOutValid}, 32'd0);
    @(negedge clk);
    ovlIdx = 8'd40; gfxPixel = 24'hA0BB11; ovlPixel = 24'h5BBB22;
    chkPix("R8 first of pair", 1'b1, 8'hAA);
    @(negedge clk);
    pixValid = 1'b0;
    chkPix("R8 second of pair", 1'b0, 8'hBB);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule